// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small bank of single-bit semaphore flags that two independent ports use to pass ownership of a shared resource back and forth. Each port has an active-low semaphore select, an active-low chip enable, a read/write strobe, an active-low output enable, a flag address and a byte-wide data path. The flags behave as tokens: a port asks for a flag by writing 0, and at any moment at most one port holds a given flag. A request made while the other port holds the flag is remembered. It is granted as soon as the holder gives the flag back by writing 1.

A write is committed on the clock in which the port's read/write strobe returns high after being low. Only bit 0 of the data byte is used. A read returns the flag as seen from that port, copied onto every data bit: 0 means "this port holds it" and 1 means "not held by this port". Read data is registered and comes with a valid strobe. Both ports run on one clock with a synchronous active-high reset.

Top module: `token_flag_unit`

## Requirements
- R1: There are NUM_FLAGS (default 8) independent flags, selected by the low ADDR_W (default 3) address bits. An operation on one flag never changes another.
- R2: A write takes its request value only from data bit 0. Data 0xFE requests a flag and data 0x01 releases it.
- R3: A read (select low, chip enable high, rw high, output enable low at a clock edge) sets rvalid to 1 and rdata to 0x00 or 0xFF one cycle later. In any cycle with no read, rvalid is 0 and rdata is 0x00.
- R4: A write commits only in a cycle where rw is 1 after being 0 in the previous cycle and, in that same cycle, select is low and chip enable is high. A strobe rising while select is high has no effect. A read needs output enable low.
- R5: Select low together with chip enable low is illegal. It commits no write and produces no read (rvalid stays 0).
- R6: Writing 0 to a flag that the other port does not hold grants the flag to the writer, whose reads then return 0x00.
- R7: Writing 0 to a flag that the other port holds leaves the writer pending, reading 0xFF. When the holder writes 1, the flag passes to the pending port on that same commit.
- R8: When both ports request the same free flag in the same cycle, the left port gets it and the right port stays pending.
- R9: After reset every flag is free and reads 0xFF from both ports, and no request is pending.
- R10: A pending port that writes 1 withdraws its request. A later release by the holder then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left chip enable, active low (must be high for flag access) |
| l_rw | input | 1 | Left read/write strobe, 1 = read, rising edge commits a write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left flag address |
| l_wdata | input | DATA_W | Left write data, bit 0 used |
| l_rdata | output | DATA_W | Left read data, flag state mirrored on all bits |
| l_rvalid | output | 1 | Left read data valid |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read/write strobe |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right flag address |
| r_wdata | input | DATA_W | Right write data, bit 0 used |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The assertions assume that each port's controls are synchronous to the clock and held steady for whole cycles. They also assume that a write strobe pulse is low for at least one full cycle before it rises, so the rise is seen as a single-cycle event. The bench drives every input on the falling clock edge. It completes each write as a full low-then-high strobe pulse with select held low, and it issues reads only with output enable low and never in the cycle a write commits on the same port. The random phase uses only legal, complete operations. Illegal select and chip-enable combinations, and strobe edges with select high, appear only in directed cases.

// File: rtl/token_pkg.sv
package token_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
endpackage

// File: rtl/token_cell.sv
module token_cell
  import token_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_l,
  input  logic val_l,
  input  logic wr_r,
  input  logic val_r,
  output logic held_l,
  output logic held_r
);
  logic req_l, req_r, nreq_l, nreq_r;
  own_e st, nst;

  always_comb begin
    nreq_l = wr_l ? ~val_l : req_l;
    nreq_r = wr_r ? ~val_r : req_r;
    nst = st;
    if (st == OWN_LEFT && !nreq_l) nst = OWN_NONE;
    if (st == OWN_RIGHT && !nreq_r) nst = OWN_NONE;
    if (nst == OWN_NONE) begin
      if (nreq_l) nst = OWN_LEFT;
      else if (nreq_r) nst = OWN_RIGHT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l <= 1'b0;
      req_r <= 1'b0;
      st    <= OWN_NONE;
    end else begin
      req_l <= nreq_l;
      req_r <= nreq_r;
      st    <= nst;
    end
  end

  assign held_l = (st == OWN_LEFT);
  assign held_r = (st == OWN_RIGHT);
endmodule

// File: rtl/token_port.sv
module token_port #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ce_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_FLAGS-1:0] held,
  output logic              wr_stb,
  output logic              wr_val,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic rw_q;
  logic legal;
  logic rd_stb;

  assign legal   = !sel_n && ce_n;
  assign wr_stb  = legal && rw && !rw_q;
  assign wr_val  = wdata[0];
  assign wr_addr = addr;
  assign rd_stb  = legal && rw && !oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_q   <= 1'b1;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rw_q   <= rw;
      rvalid <= rd_stb;
      rdata  <= rd_stb ? {DATA_W{~held[addr]}} : '0;
    end
  end
endmodule

// File: rtl/token_flag_unit.sv
module token_flag_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel_n,
  input  logic              l_ce_n,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_sel_n,
  input  logic              r_ce_n,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  logic                 wr_l, wr_r, val_l, val_r;
  logic [ADDR_W-1:0]    waddr_l, waddr_r;
  logic [NUM_FLAGS-1:0] held_l, held_r;

  token_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_left (
    .clk(clk), .rst(rst), .sel_n(l_sel_n), .ce_n(l_ce_n), .rw(l_rw),
    .oe_n(l_oe_n), .addr(l_addr), .wdata(l_wdata), .held(held_l),
    .wr_stb(wr_l), .wr_val(val_l), .wr_addr(waddr_l),
    .rdata(l_rdata), .rvalid(l_rvalid)
  );

  token_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_right (
    .clk(clk), .rst(rst), .sel_n(r_sel_n), .ce_n(r_ce_n), .rw(r_rw),
    .oe_n(r_oe_n), .addr(r_addr), .wdata(r_wdata), .held(held_r),
    .wr_stb(wr_r), .wr_val(val_r), .wr_addr(waddr_r),
    .rdata(r_rdata), .rvalid(r_rvalid)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    token_cell u_cell (
      .clk(clk), .rst(rst),
      .wr_l(wr_l && (waddr_l == ADDR_W'(i))), .val_l(val_l),
      .wr_r(wr_r && (waddr_r == ADDR_W'(i))), .val_r(val_r),
      .held_l(held_l[i]), .held_r(held_r[i])
    );
  end
endmodule

// File: rtl/token_flag_chk.sv
module token_flag_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input logic clk,
  input logic rst,
  input logic l_sel_n,
  input logic l_ce_n,
  input logic r_sel_n,
  input logic r_ce_n,
  input logic [DATA_W-1:0] l_rdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic l_rvalid,
  input logic r_rvalid,
  input logic wr_l,
  input logic wr_r,
  input logic val_l,
  input logic val_r,
  input logic [ADDR_W-1:0] waddr_l,
  input logic [ADDR_W-1:0] waddr_r,
  input logic [NUM_FLAGS-1:0] held_l,
  input logic [NUM_FLAGS-1:0] held_r
);
  // R3: read data is all zeros or all ones while valid
  a_r3_mirror_l: assert property (@(posedge clk) disable iff (rst)
    l_rvalid |-> (l_rdata == '0 || l_rdata == '1));
  a_r3_mirror_r: assert property (@(posedge clk) disable iff (rst)
    r_rvalid |-> (r_rdata == '0 || r_rdata == '1));
  // R5: illegal select/enable gives no read and no write
  a_r5_no_read_l: assert property (@(posedge clk) disable iff (rst)
    (!l_sel_n && !l_ce_n) |=> !l_rvalid);
  a_r5_no_write_r: assert property (@(posedge clk) disable iff (rst)
    (!r_sel_n && !r_ce_n) |-> !wr_r);
  // R4: ownership changes only on a committed write
  a_r4_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_l && !wr_r) |=> ($stable(held_l) && $stable(held_r)));
  // R6: left request on a flag the right does not hold is granted
  a_r6_grant_l: assert property (@(posedge clk) disable iff (rst)
    (wr_l && !val_l && !held_r[waddr_l]) |=> held_l[$past(waddr_l)]);
  // R8: simultaneous request on a free flag goes left
  a_r8_left_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_l && !val_l && wr_r && !val_r && waddr_l == waddr_r &&
     !held_l[waddr_l] && !held_r[waddr_l]) |=> held_l[$past(waddr_l)]);
  // R7: the two ports never hold the same flag
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    (wr_l || wr_r) |=> ((held_l & held_r) == '0));
endmodule

bind token_flag_unit token_flag_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .l_sel_n(l_sel_n), .l_ce_n(l_ce_n),
  .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .l_rdata(l_rdata), .r_rdata(r_rdata),
  .l_rvalid(l_rvalid), .r_rvalid(r_rvalid), .wr_l(wr_l), .wr_r(wr_r),
  .val_l(val_l), .val_r(val_r), .waddr_l(waddr_l), .waddr_r(waddr_r),
  .held_l(held_l), .held_r(held_r)
);

// File: tb/tb_token_flag_unit.sv
module tb_token_flag_unit;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel_n = 1, l_ce_n = 1, l_rw = 1, l_oe_n = 1;
  logic r_sel_n = 1, r_ce_n = 1, r_rw = 1, r_oe_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid;

  always #2.5 clk = ~clk;

  token_flag_unit #(.NUM_FLAGS(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit req_m [2][N];
  int own_m [N];  // 0 free, 1 left, 2 right

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void resolve(input int a);
    if (own_m[a] == 1 && !req_m[0][a]) own_m[a] = 0;
    if (own_m[a] == 2 && !req_m[1][a]) own_m[a] = 0;
    if (own_m[a] == 0) begin
      if (req_m[0][a]) own_m[a] = 1;
      else if (req_m[1][a]) own_m[a] = 2;
    end
  endfunction

  function automatic logic [DW-1:0] exp_rd(input int p, input int a);
    return (own_m[a] == p + 1) ? 8'h00 : 8'hFF;
  endfunction

  task automatic idle_all();
    l_sel_n = 1; l_ce_n = 1; l_rw = 1; l_oe_n = 1;
    r_sel_n = 1; r_ce_n = 1; r_rw = 1; r_oe_n = 1;
  endtask

  task automatic set_port(input int p, input bit s, input bit c, input bit w,
                          input bit o, input int a, input logic [DW-1:0] d);
    if (p == 0) begin
      l_sel_n = s; l_ce_n = c; l_rw = w; l_oe_n = o; l_addr = AW'(a); l_wdata = d;
    end else begin
      r_sel_n = s; r_ce_n = c; r_rw = w; r_oe_n = o; r_addr = AW'(a); r_wdata = d;
    end
  endtask

  // full legal write pulse on one port, model updated
  task automatic do_write(input int p, input int a, input logic [DW-1:0] d);
    @(negedge clk); set_port(p, 0, 1, 0, 1, a, d);
    @(negedge clk); set_port(p, 0, 1, 1, 1, a, d);
    @(negedge clk); set_port(p, 1, 1, 1, 1, a, d);
    req_m[p][a] = ~d[0];
    resolve(a);
  endtask

  task automatic both_write(input int a, input logic [DW-1:0] dl, input logic [DW-1:0] dr);
    @(negedge clk); set_port(0, 0, 1, 0, 1, a, dl); set_port(1, 0, 1, 0, 1, a, dr);
    @(negedge clk); l_rw = 1; r_rw = 1;
    @(negedge clk); idle_all();
    req_m[0][a] = ~dl[0];
    req_m[1][a] = ~dr[0];
    resolve(a);
  endtask

  task automatic do_read(input int p, input int a, input string tag);
    logic [DW-1:0] d;
    logic v;
    @(negedge clk); set_port(p, 0, 1, 1, 0, a, '0);
    @(negedge clk);
    d = (p == 0) ? l_rdata : r_rdata;
    v = (p == 0) ? l_rvalid : r_rvalid;
    set_port(p, 1, 1, 1, 1, a, '0);
    chk(v == 1'b1, {tag, " R3 valid"}, v, 1);
    chk(d == exp_rd(p, a), tag, d, exp_rd(p, a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      own_m[i] = 0; req_m[0][i] = 0; req_m[1][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(l_rvalid == 0 && l_rdata == 0, "R3 idle left no valid", l_rvalid, 0);
    chk(r_rvalid == 0 && r_rdata == 0, "R3 idle right no valid", r_rvalid, 0);
    // R9 reset state
    for (int a = 0; a < N; a++) begin
      do_read(0, a, "R9 reset left");
      do_read(1, a, "R9 reset right");
    end
    // R9 no pending request: right gets flag 3 at once
    do_write(1, 3, 8'h00);
    do_read(1, 3, "R9 no pending left, R6 right grant");
    do_write(1, 3, 8'h01);
    // R6 left grant, R2 bit0 only
    do_write(0, 2, 8'hFE);
    do_read(0, 2, "R2 0xFE requests, R6 left grant");
    do_read(1, 2, "R6 other port reads FF");
    // R7 pending then handoff
    do_write(1, 2, 8'h00);
    do_read(1, 2, "R7 pending reads FF");
    do_write(0, 2, 8'h01);
    do_read(1, 2, "R7 handoff to right");
    do_read(0, 2, "R7 releaser reads FF");
    do_write(1, 2, 8'hFF);
    do_read(1, 2, "R2 0xFF releases");
    // R1 independence
    do_write(0, 5, 8'h00);
    do_read(0, 4, "R1 neighbour untouched");
    do_read(0, 6, "R1 neighbour untouched");
    do_write(0, 5, 8'h01);
    // R8 simultaneous
    both_write(6, 8'h00, 8'h00);
    do_read(0, 6, "R8 left wins");
    do_read(1, 6, "R8 right pending");
    do_write(0, 6, 8'h01);
    do_read(1, 6, "R8 right after release");
    do_write(1, 6, 8'h01);
    // R10 withdraw
    do_write(0, 1, 8'h00);
    do_write(1, 1, 8'h00);
    do_write(1, 1, 8'h01);
    do_write(0, 1, 8'h01);
    do_read(1, 1, "R10 withdrawn stays free right");
    do_read(0, 1, "R10 withdrawn stays free left");
    // R5 illegal write ignored
    @(negedge clk); set_port(0, 0, 0, 0, 1, 0, 8'h00);
    @(negedge clk); l_rw = 1;
    @(negedge clk); idle_all();
    do_read(0, 0, "R5 illegal write ignored");
    // R5 illegal read
    @(negedge clk); set_port(1, 0, 0, 1, 0, 0, 8'h00);
    @(negedge clk);
    chk(r_rvalid == 0, "R5 illegal read no valid", r_rvalid, 0);
    idle_all();
    // R4 strobe rise with select high
    @(negedge clk); set_port(0, 0, 1, 0, 1, 7, 8'h00);
    @(negedge clk); l_sel_n = 1;
    @(negedge clk); l_rw = 1;
    @(negedge clk); idle_all();
    do_read(0, 7, "R4 rise with select high ignored");
    // R4 read needs output enable
    @(negedge clk); set_port(0, 0, 1, 1, 1, 0, 8'h00);
    @(negedge clk);
    chk(l_rvalid == 0, "R4 no read without output enable", l_rvalid, 0);
    idle_all();
    // random phase
    for (int k = 0; k < 400; k++) begin
      int p, a;
      p = int'($urandom_range(1, 0));
      a = int'($urandom_range(N - 1, 0));
      case ($urandom_range(2, 0))
        0: do_write(p, a, DW'($urandom));
        1: do_read(p, a, "R1 random read");
        default: both_write(a, DW'($urandom), DW'($urandom));
      endcase
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule